// File: doc/BRIEF.md
# Per-CPU Interrupt State Store

This block keeps the state bits of every interrupt for a small multi-processor interrupt controller. Enable, pending, active, group and sampled line level are each stored per interrupt as a mask with one bit per CPU. Each interrupt also has one trigger-mode flag and one delivery-model flag, which all CPUs share. Two command ports, one for setting and one for clearing, each carry a field code, an interrupt number and a CPU mask. The input lines are sampled every cycle. When an interrupt is edge-triggered, a rising line latches pending for the CPUs whose line rose.

Priorities are kept in a separate store. Interrupts below the internal boundary have one priority per CPU. Interrupts at or above the boundary share one priority, indexed by the interrupt number minus the boundary.

A combinational query port returns the state of one chosen interrupt as seen by one chosen CPU. The pending output is computed, not stored: a level-triggered interrupt reads as pending while its sampled line is high, even after its latch has been cleared. In legacy mode only the latch counts. Arbitration, register access and acknowledge sequencing are handled by neighbouring blocks.

Top module: `irq_state_array`

## Requirements
- R1: After a synchronous active-low reset, every state bit, trigger flag, model flag and priority reads zero.
- R2: A command on the set port or the clear port takes effect at the next clock edge. It ORs or clears the CPU mask into the mask field chosen by the field code: 0 enable, 1 pending, 2 active, 3 group. Field codes 6 and 7 do nothing.
- R3: When the set port and the clear port hit the same bit in one cycle, the bit ends up set.
- R4: Field code 4 selects the edge-trigger flag and code 5 selects the delivery-model flag. Each is one bit per interrupt, and a command on either one ignores the CPU mask.
- R5: The level output for CPU c reflects line_in[irq*NCPU+c] as sampled at the previous clock edge.
- R6: On an edge-triggered interrupt, a line that is high and was low at the previous sample latches pending for that CPU at the same edge. A level-triggered interrupt latches nothing from its line.
- R7: Effective pending is the latch OR the sampled level when the interrupt is level-triggered and legacy mode is low. In legacy mode it is the latch alone.
- R8: Clearing pending on an interrupt whose model flag is set clears the latch for all CPUs, whatever the mask.
- R9: A priority write with an interrupt number below NINT stores a value for the named CPU only. A write at or above NINT stores one value that every CPU reads back.
- R10: Commands, priority writes and queries with an interrupt number of NIRQ or more are ignored. The query outputs then read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| legacy_mode | input | 1 | Pending reads only the latch |
| line_in | input | NIRQ*NCPU | Interrupt lines, bit irq*NCPU+cpu |
| set_valid | input | 1 | Set command strobe |
| set_field | input | 3 | Set field code |
| set_irq | input | IRQ_W | Set interrupt number |
| set_mask | input | NCPU | Set CPU mask |
| clr_valid | input | 1 | Clear command strobe |
| clr_field | input | 3 | Clear field code |
| clr_irq | input | IRQ_W | Clear interrupt number |
| clr_mask | input | NCPU | Clear CPU mask |
| prio_we | input | 1 | Priority write strobe |
| prio_irq | input | IRQ_W | Priority write interrupt number |
| prio_cpu | input | CPU_W | Priority write CPU (banked range) |
| prio_val | input | PRIO_W | Priority value |
| q_irq | input | IRQ_W | Query interrupt number |
| q_cpu | input | CPU_W | Query CPU |
| q_enabled | output | 1 | Enable bit |
| q_pending | output | 1 | Effective pending |
| q_active | output | 1 | Active bit |
| q_group | output | 1 | Group bit |
| q_level | output | 1 | Sampled line level |
| q_edge | output | 1 | Edge-trigger flag |
| q_model | output | 1 | Delivery-model flag |
| q_prio | output | PRIO_W | Priority for this interrupt and CPU |

## Verification
Two pairs of functions can act on the same bit in one cycle. The first pair is the set port and the clear port. The second pair is a clear of pending and a pending latch caused by a line rising on an edge-triggered interrupt. The random stimulus often copies the set port's number and field onto the clear port, and it keeps toggling lines while pending clears are issued. Directed cases force both collisions and a model-flag clear. The result is judged by comparing the queried outputs with a reference model in which the set always wins.

// File: rtl/irq_state_pkg.sv
// Package: shared field codes for the interrupt state store.
// Assumes a 3-bit field code; codes above 5 select nothing.
package irq_state_pkg;
    localparam int NFLD = 6;

    typedef enum logic [2:0] {
        FLD_ENABLE = 3'd0,
        FLD_PEND   = 3'd1,
        FLD_ACTIVE = 3'd2,
        FLD_GROUP  = 3'd3,
        FLD_TRIG   = 3'd4,
        FLD_MODEL  = 3'd5
    } fld_e;

    // Turn a field code into a one-hot field select, zero for unused codes.
    function automatic logic [NFLD-1:0] field_sel(input logic [2:0] code);
        logic [NFLD-1:0] s;
        s = '0;
        case (fld_e'(code))
            FLD_ENABLE: s[0] = 1'b1;
            FLD_PEND:   s[1] = 1'b1;
            FLD_ACTIVE: s[2] = 1'b1;
            FLD_GROUP:  s[3] = 1'b1;
            FLD_TRIG:   s[4] = 1'b1;
            FLD_MODEL:  s[5] = 1'b1;
            default:    s = '0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/irq_cell.sv
// irq_cell: the state of one interrupt. It holds five per-CPU masks and two shared flags.
// Assumes the field selects are already qualified by interrupt number. A set
// wins over a clear on the same bit. The pending latch is also set by a rising
// line when the edge flag is set. A pending clear covers all CPUs when the
// model flag is set.
module irq_cell #(
    parameter int NCPU = 4,
    parameter int NFLD = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NFLD-1:0] set_sel,
    input  logic [NFLD-1:0] clr_sel,
    input  logic [NCPU-1:0] set_mask,
    input  logic [NCPU-1:0] clr_mask,
    input  logic [NCPU-1:0] line,
    output logic [NCPU-1:0] en_q,
    output logic [NCPU-1:0] pend_q,
    output logic [NCPU-1:0] act_q,
    output logic [NCPU-1:0] grp_q,
    output logic [NCPU-1:0] lvl_q,
    output logic            edge_q,
    output logic            model_q
);
    logic [NCPU-1:0] rise;
    logic [NCPU-1:0] p_set;
    logic [NCPU-1:0] p_clr;

    // Derive the pending set and clear masks from commands, line edges and the model flag.
    always_comb begin
        rise  = edge_q ? (line & ~lvl_q) : '0;
        p_set = (set_sel[1] ? set_mask : '0) | rise;
        p_clr = clr_sel[1] ? (model_q ? '1 : clr_mask) : '0;
    end

    // Update every state field at the clock edge, with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            pend_q  <= '0;
            act_q   <= '0;
            grp_q   <= '0;
            lvl_q   <= '0;
            edge_q  <= 1'b0;
            model_q <= 1'b0;
        end else begin
            en_q    <= (en_q  & ~(clr_sel[0] ? clr_mask : '0)) | (set_sel[0] ? set_mask : '0);
            pend_q  <= (pend_q & ~p_clr) | p_set;
            act_q   <= (act_q & ~(clr_sel[2] ? clr_mask : '0)) | (set_sel[2] ? set_mask : '0);
            grp_q   <= (grp_q & ~(clr_sel[3] ? clr_mask : '0)) | (set_sel[3] ? set_mask : '0);
            lvl_q   <= line;
            edge_q  <= set_sel[4] | (edge_q & ~clr_sel[4]);
            model_q <= set_sel[5] | (model_q & ~clr_sel[5]);
        end
    end

    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_sel[0] |=> ((en_q & $past(set_mask)) == $past(set_mask)));

    a_r2_clear_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sel[2] && !set_sel[2]) |=> ((act_q & $past(clr_mask)) == '0));

    a_r5_level_sample: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lvl_q == $past(line)));

    a_r6_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
        edge_q |=> ((pend_q & $past(line & ~lvl_q)) == $past(line & ~lvl_q)));

    a_r8_model_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sel[1] && model_q && !set_sel[1] && (rise == '0)) |=> (pend_q == '0));
endmodule

// File: rtl/prio_store.sv
// prio_store: priority storage. Interrupts below NINT have one priority per CPU.
// Interrupts from NINT up to NIRQ share one priority. Writes with an interrupt
// number at or above NIRQ are dropped, and reads of such numbers return zero.
module prio_store #(
    parameter int NCPU   = 4,
    parameter int NIRQ   = 64,
    parameter int NINT   = 32,
    parameter int PRIO_W = 8,
    parameter int IRQ_W  = $clog2(NIRQ) + 1,
    parameter int CPU_W  = $clog2(NCPU)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IRQ_W-1:0]  w_irq,
    input  logic [CPU_W-1:0]  w_cpu,
    input  logic [PRIO_W-1:0] w_val,
    input  logic [IRQ_W-1:0]  r_irq,
    input  logic [CPU_W-1:0]  r_cpu,
    output logic [PRIO_W-1:0] r_val
);
    localparam int NSH  = NIRQ - NINT;
    localparam int BK_W = (NINT > 1) ? $clog2(NINT) : 1;
    localparam int SH_W = (NSH > 1) ? $clog2(NSH) : 1;
    localparam logic [IRQ_W-1:0] NIRQ_V = IRQ_W'(NIRQ);
    localparam logic [IRQ_W-1:0] NINT_V = IRQ_W'(NINT);

    logic [PRIO_W-1:0] bank   [NINT][NCPU];
    logic [PRIO_W-1:0] shared [NSH];

    // Store a priority in the banked or the shared array, or clear both on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NINT; i++)
                for (int c = 0; c < NCPU; c++)
                    bank[i][c] <= '0;
            for (int i = 0; i < NSH; i++)
                shared[i] <= '0;
        end else if (we && (w_irq < NIRQ_V)) begin
            if (w_irq < NINT_V)
                bank[BK_W'(w_irq)][w_cpu] <= w_val;
            else
                shared[SH_W'(w_irq - NINT_V)] <= w_val;
        end
    end

    // Read the priority that applies to the queried interrupt and CPU.
    always_comb begin
        if (r_irq >= NIRQ_V)
            r_val = '0;
        else if (r_irq < NINT_V)
            r_val = bank[BK_W'(r_irq)][r_cpu];
        else
            r_val = shared[SH_W'(r_irq - NINT_V)];
    end

    logic              chk_bank;
    logic              chk_sh;
    logic [BK_W-1:0]   chk_bidx;
    logic [SH_W-1:0]   chk_sidx;
    logic [CPU_W-1:0]  chk_cpu;
    logic [PRIO_W-1:0] chk_val;

    // Remember the last accepted write so the next edge can confirm it landed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_bank <= 1'b0;
            chk_sh   <= 1'b0;
            chk_bidx <= '0;
            chk_sidx <= '0;
            chk_cpu  <= '0;
            chk_val  <= '0;
        end else begin
            chk_bank <= we && (w_irq < NINT_V);
            chk_sh   <= we && (w_irq >= NINT_V) && (w_irq < NIRQ_V);
            chk_bidx <= BK_W'(w_irq);
            chk_sidx <= SH_W'(w_irq - NINT_V);
            chk_cpu  <= w_cpu;
            chk_val  <= w_val;
        end
    end

    // Check that the previous accepted write is held in the right array.
    always_ff @(posedge clk) begin
        if (rst_n && chk_bank)
            a_r9_bank_write: assert (bank[chk_bidx][chk_cpu] == chk_val);
        if (rst_n && chk_sh)
            a_r9_shared_write: assert (shared[chk_sidx] == chk_val);
    end
endmodule

// File: rtl/irq_state_array.sv
// irq_state_array: top of the interrupt state store. It decodes the set and clear
// commands per interrupt, holds one irq_cell per interrupt plus the priority
// store, and answers one (interrupt, CPU) query combinationally.
// Assumes line_in bit irq*NCPU+cpu is the line of interrupt irq toward CPU cpu.
module irq_state_array
    import irq_state_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int NIRQ   = 64,
    parameter int NINT   = 32,
    parameter int PRIO_W = 8,
    localparam int IRQ_W = $clog2(NIRQ) + 1,
    localparam int CPU_W = $clog2(NCPU)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 legacy_mode,
    input  logic [NIRQ*NCPU-1:0] line_in,
    input  logic                 set_valid,
    input  logic [2:0]           set_field,
    input  logic [IRQ_W-1:0]     set_irq,
    input  logic [NCPU-1:0]      set_mask,
    input  logic                 clr_valid,
    input  logic [2:0]           clr_field,
    input  logic [IRQ_W-1:0]     clr_irq,
    input  logic [NCPU-1:0]      clr_mask,
    input  logic                 prio_we,
    input  logic [IRQ_W-1:0]     prio_irq,
    input  logic [CPU_W-1:0]     prio_cpu,
    input  logic [PRIO_W-1:0]    prio_val,
    input  logic [IRQ_W-1:0]     q_irq,
    input  logic [CPU_W-1:0]     q_cpu,
    output logic                 q_enabled,
    output logic                 q_pending,
    output logic                 q_active,
    output logic                 q_group,
    output logic                 q_level,
    output logic                 q_edge,
    output logic                 q_model,
    output logic [PRIO_W-1:0]    q_prio
);
    localparam int LIRQ = $clog2(NIRQ);
    localparam logic [IRQ_W-1:0] NIRQ_V = IRQ_W'(NIRQ);

    logic [NCPU-1:0] en_a   [NIRQ];
    logic [NCPU-1:0] pend_a [NIRQ];
    logic [NCPU-1:0] act_a  [NIRQ];
    logic [NCPU-1:0] grp_a  [NIRQ];
    logic [NCPU-1:0] lvl_a  [NIRQ];
    logic            edge_a [NIRQ];
    logic            model_a[NIRQ];

    logic [NFLD-1:0] set_code;
    logic [NFLD-1:0] clr_code;

    // Decode the field codes once for all cells.
    always_comb begin
        set_code = set_valid ? field_sel(set_field) : '0;
        clr_code = clr_valid ? field_sel(clr_field) : '0;
    end

    for (genvar i = 0; i < NIRQ; i++) begin : g_cell
        logic [NFLD-1:0] s_sel;
        logic [NFLD-1:0] c_sel;

        // Qualify the decoded fields by interrupt number.
        always_comb begin
            s_sel = (set_irq == IRQ_W'(i)) ? set_code : '0;
            c_sel = (clr_irq == IRQ_W'(i)) ? clr_code : '0;
        end

        irq_cell #(.NCPU(NCPU), .NFLD(NFLD)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_sel  (s_sel),
            .clr_sel  (c_sel),
            .set_mask (set_mask),
            .clr_mask (clr_mask),
            .line     (line_in[i*NCPU +: NCPU]),
            .en_q     (en_a[i]),
            .pend_q   (pend_a[i]),
            .act_q    (act_a[i]),
            .grp_q    (grp_a[i]),
            .lvl_q    (lvl_a[i]),
            .edge_q   (edge_a[i]),
            .model_q  (model_a[i])
        );
    end

    prio_store #(
        .NCPU(NCPU), .NIRQ(NIRQ), .NINT(NINT), .PRIO_W(PRIO_W),
        .IRQ_W(IRQ_W), .CPU_W(CPU_W)
    ) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (prio_we),
        .w_irq (prio_irq),
        .w_cpu (prio_cpu),
        .w_val (prio_val),
        .r_irq (q_irq),
        .r_cpu (q_cpu),
        .r_val (q_prio)
    );

    logic [LIRQ-1:0] qi;
    logic            q_ok;
    logic            lvl_bit;

    // Select the queried interrupt's bits and form effective pending.
    always_comb begin
        qi        = LIRQ'(q_irq);
        q_ok      = (q_irq < NIRQ_V);
        lvl_bit   = lvl_a[qi][q_cpu];
        q_enabled = q_ok & en_a[qi][q_cpu];
        q_active  = q_ok & act_a[qi][q_cpu];
        q_group   = q_ok & grp_a[qi][q_cpu];
        q_level   = q_ok & lvl_bit;
        q_edge    = q_ok & edge_a[qi];
        q_model   = q_ok & model_a[qi];
        q_pending = q_ok & (pend_a[qi][q_cpu] |
                    (!legacy_mode & !edge_a[qi] & lvl_bit));
    end

    // Out-of-range queries must read as all zero.
    always_ff @(posedge clk) begin
        if (rst_n && !q_ok)
            a_r10_unknown_quiet: assert ({q_enabled, q_pending, q_active, q_group,
                                          q_level, q_edge, q_model, q_prio} == '0);
    end

    // The sampled line can only count as pending when level-triggered and not in legacy mode.
    a_r7_legacy_latch_only: assert property (@(posedge clk) disable iff (!rst_n)
        (q_ok && legacy_mode) |-> (q_pending == pend_a[qi][q_cpu]));
endmodule

// File: tb/test_irq_state_array.sv
`timescale 1ns/1ps
module test_irq_state_array;
    localparam int NC = 4, NI = 64, NT = 32, PW = 8, IW = 7, CW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic legacy_mode = 1'b0;
    logic [NI*NC-1:0] line_in = '0;
    logic set_valid = 1'b0, clr_valid = 1'b0, prio_we = 1'b0;
    logic [2:0] set_field = '0, clr_field = '0;
    logic [IW-1:0] set_irq = '0, clr_irq = '0, prio_irq = '0, q_irq = '0;
    logic [NC-1:0] set_mask = '0, clr_mask = '0;
    logic [CW-1:0] prio_cpu = '0, q_cpu = '0;
    logic [PW-1:0] prio_val = '0;
    logic q_enabled, q_pending, q_active, q_group, q_level, q_edge, q_model;
    logic [PW-1:0] q_prio;

    irq_state_array #(.NCPU(NC), .NIRQ(NI), .NINT(NT), .PRIO_W(PW)) i_irq_state_array (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .line_in(line_in),
        .set_valid(set_valid), .set_field(set_field), .set_irq(set_irq), .set_mask(set_mask),
        .clr_valid(clr_valid), .clr_field(clr_field), .clr_irq(clr_irq), .clr_mask(clr_mask),
        .prio_we(prio_we), .prio_irq(prio_irq), .prio_cpu(prio_cpu), .prio_val(prio_val),
        .q_irq(q_irq), .q_cpu(q_cpu), .q_enabled(q_enabled), .q_pending(q_pending),
        .q_active(q_active), .q_group(q_group), .q_level(q_level), .q_edge(q_edge),
        .q_model(q_model), .q_prio(q_prio)
    );

    always #5 clk = ~clk;

    bit [NC-1:0] m_en[NI], m_pd[NI], m_ac[NI], m_gp[NI], m_lv[NI];
    bit          m_ed[NI], m_md[NI];
    bit [PW-1:0] m_bk[NT][NC];
    bit [PW-1:0] m_sh[NI-NT];
    int vec = 0, bad = 0;
    bit done = 1'b0;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        vec++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s irq=%0d cpu=%0d actual=%0h expected=%0h", tag, q_irq, q_cpu, got, exp);
        end
    endtask

    // Compare every query output with the reference model.
    task automatic compare();
        int i, c;
        bit e_en, e_pd, e_ac, e_gp, e_lv, e_ed, e_md;
        bit [PW-1:0] e_pr;
        i = int'(q_irq); c = int'(q_cpu);
        {e_en, e_pd, e_ac, e_gp, e_lv, e_ed, e_md} = '0;
        e_pr = '0;
        if (i < NI) begin
            e_en = m_en[i][c]; e_ac = m_ac[i][c]; e_gp = m_gp[i][c];
            e_lv = m_lv[i][c]; e_ed = m_ed[i];    e_md = m_md[i];
            e_pd = m_pd[i][c] | (!legacy_mode && !m_ed[i] && m_lv[i][c]);
            e_pr = (i < NT) ? m_bk[i][c] : m_sh[i-NT];
        end
        chk("R2/R3/R10 enable",  32'(q_enabled), 32'(e_en));
        chk("R6/R7/R8 pending",  32'(q_pending), 32'(e_pd));
        chk("R2 active",         32'(q_active),  32'(e_ac));
        chk("R2 group",          32'(q_group),   32'(e_gp));
        chk("R5 level",          32'(q_level),   32'(e_lv));
        chk("R4 edge flag",      32'(q_edge),    32'(e_ed));
        chk("R4 model flag",     32'(q_model),   32'(e_md));
        chk("R9 priority",       32'(q_prio),    32'(e_pr));
    endtask

    function automatic bit [5:0] fsel(bit v, logic [IW-1:0] irq, logic [2:0] f, int i);
        if (v && int'(irq) == i && f < 3'd6) return 6'(1 << f);
        return '0;
    endfunction

    // Apply the current inputs to the model as the design applies them at one edge.
    task automatic model_update();
        for (int i = 0; i < NI; i++) begin
            bit [5:0] ss, cs;
            bit [NC-1:0] rise, pclr, ln;
            ss = fsel(set_valid, set_irq, set_field, i);
            cs = fsel(clr_valid, clr_irq, clr_field, i);
            ln = line_in[i*NC +: NC];
            rise = m_ed[i] ? (ln & ~m_lv[i]) : '0;
            pclr = cs[1] ? (m_md[i] ? '1 : clr_mask) : '0;
            m_en[i] = (m_en[i] & ~(cs[0] ? clr_mask : '0)) | (ss[0] ? set_mask : '0);
            m_pd[i] = (m_pd[i] & ~pclr) | (ss[1] ? set_mask : '0) | rise;
            m_ac[i] = (m_ac[i] & ~(cs[2] ? clr_mask : '0)) | (ss[2] ? set_mask : '0);
            m_gp[i] = (m_gp[i] & ~(cs[3] ? clr_mask : '0)) | (ss[3] ? set_mask : '0);
            m_lv[i] = ln;
            m_ed[i] = ss[4] | (m_ed[i] & !cs[4]);
            m_md[i] = ss[5] | (m_md[i] & !cs[5]);
        end
        if (prio_we && int'(prio_irq) < NI) begin
            if (int'(prio_irq) < NT) m_bk[prio_irq][prio_cpu] = prio_val;
            else m_sh[int'(prio_irq) - NT] = prio_val;
        end
    endtask

    // Check before the edge, then advance the model over the edge.
    task automatic step();
        #1 compare();
        @(posedge clk);
        #1 model_update();
        @(negedge clk);
    endtask

    task automatic idle();
        set_valid = 0; clr_valid = 0; prio_we = 0;
    endtask

    task automatic do_set(int f, int irq, int m);
        set_valid = 1; set_field = 3'(f); set_irq = IW'(irq); set_mask = NC'(m);
    endtask

    task automatic do_clr(int f, int irq, int m);
        clr_valid = 1; clr_field = 3'(f); clr_irq = IW'(irq); clr_mask = NC'(m);
    endtask

    task automatic query(int irq, int cpu);
        q_irq = IW'(irq); q_cpu = CW'(cpu);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NI; i++) begin
            m_en[i] = '0; m_pd[i] = '0; m_ac[i] = '0; m_gp[i] = '0; m_lv[i] = '0;
            m_ed[i] = 0; m_md[i] = 0;
        end
        for (int i = 0; i < NT; i++) for (int c = 0; c < NC; c++) m_bk[i][c] = '0;
        for (int i = 0; i < NI - NT; i++) m_sh[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state on a banked and a shared interrupt
        query(5, 2); step();
        query(45, 1); step();

        // R3: set and clear of enable collide on interrupt 3
        do_set(0, 3, 4'hF); do_clr(0, 3, 4'h5); step();
        idle(); query(3, 0); step();
        query(3, 2); step();

        // R8: model-flag interrupt 40 has its pending cleared for every CPU
        do_set(5, 40, 4'h1); step();
        do_set(1, 40, 4'hF); step();
        idle(); do_clr(1, 40, 4'h1); step();
        idle(); query(40, 3); step();

        // R6, R7: level-triggered interrupt 10, line of CPU 1 high, then legacy mode
        line_in[10*NC+1] = 1'b1; step();
        query(10, 1); step();
        legacy_mode = 1; step();
        legacy_mode = 0;
        // R6: make interrupt 10 edge-triggered and raise the line of CPU 2
        do_set(4, 10, 4'h0); step();
        idle(); line_in[10*NC+2] = 1'b1; step();
        query(10, 2); step();
        // R6: a clear colliding with a rising line still ends pending
        line_in[10*NC+2] = 1'b0; step();
        do_clr(1, 10, 4'h4); line_in[10*NC+2] = 1'b1; step();
        idle(); step();

        // R10: an unknown interrupt number changes nothing
        do_set(0, 100, 4'hF); step();
        idle(); query(100, 0); step();
        query(36, 0); step();

        // R9: banked and shared priority writes
        prio_we = 1; prio_irq = 7; prio_cpu = 0; prio_val = 8'h11; step();
        prio_cpu = 1; prio_val = 8'h22; step();
        prio_irq = 50; prio_cpu = 3; prio_val = 8'h33; step();
        prio_we = 0;
        query(7, 0); step(); query(7, 1); step(); query(7, 2); step();
        query(50, 0); step(); query(50, 2); step();

        // R2, R4, R5: constrained random traffic with frequent collisions
        for (int n = 0; n < 3000; n++) begin
            set_valid = 1'($urandom % 2);
            set_field = 3'($urandom % 8);
            set_irq   = IW'($urandom % 72);
            set_mask  = NC'($urandom);
            clr_valid = 1'($urandom % 2);
            if ($urandom % 4 == 0) begin
                clr_field = set_field; clr_irq = set_irq;
            end else begin
                clr_field = 3'($urandom % 8);
                clr_irq   = IW'($urandom % 72);
            end
            clr_mask = NC'($urandom);
            prio_we  = 1'($urandom % 4 == 0);
            prio_irq = IW'($urandom % 72);
            prio_cpu = CW'($urandom);
            prio_val = PW'($urandom);
            for (int k = 0; k < 6; k++) line_in[$urandom % (NI*NC)] ^= 1'b1;
            if ($urandom % 64 == 0) legacy_mode = ~legacy_mode;
            query(int'($urandom % 72), int'($urandom % NC));
            step();
        end
        idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule